// File: doc/BRIEF.md
# Clock-Recovery Lock-Mode Controller

This block supervises a receiver's clock-recovery loop and decides whether the loop's oscillator follows the local reference clock or the incoming data. It measures frequency by counting reference-clock cycles across a window of 2^WIN_LOG2 cycles of a divided recovered clock. A toggle handshake carries each window boundary into the reference domain. The measured count is compared with the nominal count against a deviation chosen from a table of parts-per-million thresholds. Two override inputs can force either steering mode. When both are low, the block switches over automatically.

The decision logic is a four-state machine in the reference-clock domain:
- `ST_REF_SEEK` is reference-steered and counts consecutive in-range windows.
- `ST_DATA_AUTO` is data-steered and was reached automatically.
- `ST_FORCE_REF` is reference-steered and held by the override.
- `ST_FORCE_DATA` is data-steered and held by the override.

The transitions are:
- `SEEK_TO_DATA` fires on the GOOD_WINDOWS-th consecutive in-range window.
- `SEEK_MISS` fires on an out-of-range window and clears the good-window count.
- `DATA_TO_SEEK` fires on any out-of-range window while in `ST_DATA_AUTO`.
- `ANY_TO_FORCE_DATA` fires when the data override is high. It has the highest priority.
- `ANY_TO_FORCE_REF` fires when only the reference override is high.
- `FORCE_RELEASE` fires when both overrides are low in a forced state, and goes to `ST_REF_SEEK` with the count cleared.

Top module: `lockmode_ctrl`

## Requirements
- R1: While `lock_to_data_i` is 1, the block selects data-steered mode (`mode_data_o` = 1) within 5 reference cycles and holds it, whatever `lock_to_ref_i` and the clock frequencies are.
- R2: While `lock_to_data_i` is 0 and `lock_to_ref_i` is 1, `mode_data_o` is 0 within 5 reference cycles and stays 0 even with matched clocks.
- R3: With both override inputs at 0, the block runs the automatic switchover of R6 and R7.
- R4: A window is 2^WIN_LOG2 recovered-clock cycles. The reference cycles between two successive window boundaries, as seen in the reference domain, form the measured count. The first boundary after reset only arms the meter and yields no result.
- R5: `ppm_sel_i` codes 0 to 7 choose 62.5, 100, 125, 200, 250, 300, 500 and 1000 ppm. A window is in range when |count - 2^WIN_LOG2| <= floor(2^WIN_LOG2 * ppm / 10^6) + GUARD.
- R6: In automatic mode, data-steered mode is entered only on the GOOD_WINDOWS-th (default 4) consecutive in-range window. An out-of-range window restarts the run.
- R7: In `ST_DATA_AUTO`, a single out-of-range window returns the block to reference-steered mode.
- R8: `freq_locked_o` equals `mode_data_o` at all times.
- R9: While `rst_n` is 0, both outputs are 0 and the meter and the good-window count are cleared.
- R10: Releasing both overrides from a forced state enters `ST_REF_SEEK` with a zero count, so a full new run of in-range windows is needed to lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; the FSM and meter run on it |
| rec_clk | input | 1 | Divided recovered clock that times the window |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| lock_to_data_i | input | 1 | Override forcing data-steered mode (asynchronous) |
| lock_to_ref_i | input | 1 | Override forcing reference-steered mode (asynchronous) |
| ppm_sel_i | input | 3 | Threshold code, quasi-static |
| mode_data_o | output | 1 | 1 = loop steered by data, 0 = by reference |
| freq_locked_o | output | 1 | Data-lock status flag |

## Verification
The bench builds the block with WIN_LOG2 = 11 and GUARD = 1. With these values a window lasts about 2048 reference cycles, so runs of four or five windows fit comfortably in the run. The allowed deviation is 1 count at code 0 and 3 counts at code 7. A recovered clock slowed by about 0.12 % then lands at 2 or 3 counts: inside the wide threshold but outside the narrow one. This makes the threshold choice observable at the outputs. A 1 % offset serves as a clearly failing frequency for the drop, forced-mode and release cases.

// File: rtl/lockmode_pkg.sv
package lockmode_pkg;

    typedef enum logic [1:0] {
        ST_REF_SEEK   = 2'd0,
        ST_DATA_AUTO  = 2'd1,
        ST_FORCE_REF  = 2'd2,
        ST_FORCE_DATA = 2'd3
    } lock_state_e;

    // threshold in half-ppm units, indexed by the select code
    function automatic longint unsigned ppm_halves(input int sel);
        case (sel)
            0:       return 64'd125;
            1:       return 64'd200;
            2:       return 64'd250;
            3:       return 64'd400;
            4:       return 64'd500;
            5:       return 64'd600;
            6:       return 64'd1000;
            default: return 64'd2000;
        endcase
    endfunction

    // allowed count deviation for a window of 2^win_log2 cycles
    function automatic longint unsigned ppm_dev(input int win_log2, input int sel,
                                                input int guard);
        return (((64'd1 << win_log2) * ppm_halves(sel)) / 64'd2000000)
               + longint'(guard);
    endfunction

endpackage

// File: rtl/lockmode_sync.sv
module lockmode_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/lockmode_window.sv
module lockmode_window #(
    parameter int WIN_LOG2 = 12
) (
    input  logic rec_clk,
    input  logic rst_n,
    output logic tick_tgl_o
);

    logic [WIN_LOG2-1:0] cyc_q;

    // toggles once per 2^WIN_LOG2 recovered cycles
    always_ff @(posedge rec_clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q      <= '0;
            tick_tgl_o <= 1'b0;
        end else begin
            cyc_q <= cyc_q + 1'b1;
            if (&cyc_q) tick_tgl_o <= ~tick_tgl_o;
        end
    end

endmodule

// File: rtl/lockmode_meter.sv
module lockmode_meter
    import lockmode_pkg::*;
#(
    parameter int WIN_LOG2 = 12,
    parameter int GUARD    = 1
) (
    input  logic       ref_clk,
    input  logic       rst_n,
    input  logic       tick_s_i,
    input  logic [2:0] ppm_sel_i,
    output logic       win_valid_o,
    output logic       win_ok_o
);

    localparam int CW = WIN_LOG2 + 2;
    localparam logic [CW-1:0] NOMINAL = CW'(1) << WIN_LOG2;

    logic [CW-1:0] dev_tab [8];

    genvar g;
    generate
        for (g = 0; g < 8; g++) begin : g_dev
            localparam longint unsigned DEV = ppm_dev(WIN_LOG2, g, GUARD);
            assign dev_tab[g] = CW'(DEV);
        end
    endgenerate

    logic          tick_d_q;
    logic          armed_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] meas;
    logic [CW-1:0] diff;
    logic          boundary;
    logic          in_range;

    assign boundary = tick_s_i ^ tick_d_q;
    assign meas     = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
    assign diff     = (meas >= NOMINAL) ? meas - NOMINAL : NOMINAL - meas;
    assign in_range = (diff <= dev_tab[ppm_sel_i]);

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_d_q    <= 1'b0;
            armed_q     <= 1'b0;
            cnt_q       <= '0;
            win_valid_o <= 1'b0;
            win_ok_o    <= 1'b0;
        end else begin
            tick_d_q    <= tick_s_i;
            win_valid_o <= 1'b0;
            if (boundary) begin
                cnt_q       <= '0;
                armed_q     <= 1'b1;
                win_valid_o <= armed_q;
                win_ok_o    <= in_range;
            end else if (!(&cnt_q)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lockmode_fsm.sv
module lockmode_fsm
    import lockmode_pkg::*;
#(
    parameter int GOOD_WINDOWS = 4,
    parameter int GCW          = 3
) (
    input  logic           ref_clk,
    input  logic           rst_n,
    input  logic           ov_data_i,
    input  logic           ov_ref_i,
    input  logic           win_valid_i,
    input  logic           win_ok_i,
    output lock_state_e    state_o,
    output logic [GCW-1:0] good_cnt_o,
    output logic           mode_data_o,
    output logic           freq_locked_o
);

    localparam logic [GCW-1:0] LAST_GOOD = GCW'(GOOD_WINDOWS - 1);

    lock_state_e    state_q, state_d;
    logic [GCW-1:0] good_q, good_d;

    always_comb begin
        state_d = state_q;
        good_d  = good_q;
        if (ov_data_i) begin
            state_d = ST_FORCE_DATA;
            good_d  = '0;
        end else if (ov_ref_i) begin
            state_d = ST_FORCE_REF;
            good_d  = '0;
        end else begin
            unique case (state_q)
                ST_FORCE_REF, ST_FORCE_DATA: begin
                    state_d = ST_REF_SEEK;
                    good_d  = '0;
                end
                ST_REF_SEEK: begin
                    if (win_valid_i) begin
                        if (!win_ok_i) begin
                            good_d = '0;
                        end else if (good_q == LAST_GOOD) begin
                            state_d = ST_DATA_AUTO;
                            good_d  = '0;
                        end else begin
                            good_d = good_q + 1'b1;
                        end
                    end
                end
                ST_DATA_AUTO: begin
                    if (win_valid_i && !win_ok_i) begin
                        state_d = ST_REF_SEEK;
                        good_d  = '0;
                    end
                end
                default: begin
                    state_d = ST_REF_SEEK;
                    good_d  = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_REF_SEEK;
            good_q  <= '0;
        end else begin
            state_q <= state_d;
            good_q  <= good_d;
        end
    end

    // registered outputs
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_data_o   <= 1'b0;
            freq_locked_o <= 1'b0;
        end else begin
            unique case (state_q)
                ST_DATA_AUTO, ST_FORCE_DATA: begin
                    mode_data_o   <= 1'b1;
                    freq_locked_o <= 1'b1;
                end
                default: begin
                    mode_data_o   <= 1'b0;
                    freq_locked_o <= 1'b0;
                end
            endcase
        end
    end

    assign state_o    = state_q;
    assign good_cnt_o = good_q;

endmodule

// File: rtl/lockmode_ctrl.sv
module lockmode_ctrl
    import lockmode_pkg::*;
#(
    parameter int WIN_LOG2     = 12,
    parameter int GUARD        = 1,
    parameter int GOOD_WINDOWS = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       ref_clk,
    input  logic       rec_clk,
    input  logic       rst_n,
    input  logic       lock_to_data_i,
    input  logic       lock_to_ref_i,
    input  logic [2:0] ppm_sel_i,
    output logic       mode_data_o,
    output logic       freq_locked_o
);

    localparam int GCW = $clog2(GOOD_WINDOWS + 1);

    logic           tick_tgl;
    logic [2:0]     sync_out;
    logic           ov_data_s;
    logic           ov_ref_s;
    logic           tick_s;
    logic           win_valid;
    logic           win_ok;
    lock_state_e    state_q;
    logic [GCW-1:0] good_cnt;

    lockmode_window #(.WIN_LOG2(WIN_LOG2)) u_window (
        .rec_clk    (rec_clk),
        .rst_n      (rst_n),
        .tick_tgl_o (tick_tgl)
    );

    lockmode_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d_i   ({tick_tgl, lock_to_ref_i, lock_to_data_i}),
        .q_o   (sync_out)
    );

    assign ov_data_s = sync_out[0];
    assign ov_ref_s  = sync_out[1];
    assign tick_s    = sync_out[2];

    lockmode_meter #(.WIN_LOG2(WIN_LOG2), .GUARD(GUARD)) u_meter (
        .ref_clk     (ref_clk),
        .rst_n       (rst_n),
        .tick_s_i    (tick_s),
        .ppm_sel_i   (ppm_sel_i),
        .win_valid_o (win_valid),
        .win_ok_o    (win_ok)
    );

    lockmode_fsm #(.GOOD_WINDOWS(GOOD_WINDOWS), .GCW(GCW)) u_fsm (
        .ref_clk       (ref_clk),
        .rst_n         (rst_n),
        .ov_data_i     (ov_data_s),
        .ov_ref_i      (ov_ref_s),
        .win_valid_i   (win_valid),
        .win_ok_i      (win_ok),
        .state_o       (state_q),
        .good_cnt_o    (good_cnt),
        .mode_data_o   (mode_data_o),
        .freq_locked_o (freq_locked_o)
    );

endmodule

// File: rtl/lockmode_checker.sv
module lockmode_checker
    import lockmode_pkg::*;
#(
    parameter int GOOD_WINDOWS = 4,
    parameter int GCW          = 3
) (
    input logic           ref_clk,
    input logic           rst_n,
    input logic           ov_data_s,
    input logic           ov_ref_s,
    input logic           win_valid,
    input logic           win_ok,
    input lock_state_e    state_q,
    input logic [GCW-1:0] good_cnt,
    input logic           mode_data_o,
    input logic           freq_locked_o
);

    p_force_data_r1: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $past(ov_data_s, 2) |-> mode_data_o);

    p_force_ref_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $past(!ov_data_s && ov_ref_s, 2) |-> !mode_data_o);

    p_entry_run_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state_q == ST_DATA_AUTO && $past(state_q) != ST_DATA_AUTO)
        |-> $past(win_valid && win_ok && good_cnt == GCW'(GOOD_WINDOWS - 1)));

    p_run_bound_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        good_cnt < GCW'(GOOD_WINDOWS));

    p_drop_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $past(state_q == ST_DATA_AUTO && win_valid && !win_ok && !ov_data_s && !ov_ref_s)
        |-> state_q == ST_REF_SEEK);

    p_reset_r9: assert property (@(posedge ref_clk)
        !rst_n |-> (!mode_data_o && !freq_locked_o));

    p_release_r10: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ($past(state_q == ST_FORCE_REF || state_q == ST_FORCE_DATA)
         && $past(!ov_data_s && !ov_ref_s))
        |-> (state_q == ST_REF_SEEK && good_cnt == '0));

endmodule

bind lockmode_ctrl lockmode_checker #(
    .GOOD_WINDOWS(GOOD_WINDOWS),
    .GCW($clog2(GOOD_WINDOWS + 1))
) u_lockmode_checker (
    .ref_clk       (ref_clk),
    .rst_n         (rst_n),
    .ov_data_s     (ov_data_s),
    .ov_ref_s      (ov_ref_s),
    .win_valid     (win_valid),
    .win_ok        (win_ok),
    .state_q       (state_q),
    .good_cnt      (good_cnt),
    .mode_data_o   (mode_data_o),
    .freq_locked_o (freq_locked_o)
);

// File: tb/test_lockmode_ctrl.sv
`timescale 1ns/1ps
module test_lockmode_ctrl;

    localparam int WIN_LOG2 = 11;
    localparam int WIN      = 1 << WIN_LOG2;

    logic       ref_clk = 1'b0;
    logic       rec_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lock_to_data_i = 1'b0;
    logic       lock_to_ref_i = 1'b0;
    logic [2:0] ppm_sel_i = 3'd0;
    logic       mode_data_o;
    logic       freq_locked_o;

    real rec_half = 2.5;
    int  n_checks = 0;
    int  n_fail = 0;
    int  r8_mismatch = 0;
    bit  done = 1'b0;

    always #2.5 ref_clk = ~ref_clk;   // 200 MHz

    initial begin
        #1.3;
        forever #(rec_half) rec_clk = ~rec_clk;
    end

    lockmode_ctrl #(.WIN_LOG2(WIN_LOG2), .GUARD(1)) i_lockmode_ctrl (
        .ref_clk        (ref_clk),
        .rec_clk        (rec_clk),
        .rst_n          (rst_n),
        .lock_to_data_i (lock_to_data_i),
        .lock_to_ref_i  (lock_to_ref_i),
        .ppm_sel_i      (ppm_sel_i),
        .mode_data_o    (mode_data_o),
        .freq_locked_o  (freq_locked_o)
    );

    // R8: flag and mode must agree at every sample
    always @(negedge ref_clk) if (freq_locked_o !== mode_data_o) r8_mismatch++;

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge ref_clk);
        @(negedge ref_clk);
    endtask

    task automatic wait_windows(input real w);
        wait_cycles(int'(w * real'(WIN)));
    endtask

    task automatic do_reset();
        @(negedge ref_clk);
        rst_n = 1'b0;
        wait_cycles(10);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        @(negedge ref_clk);
        rst_n = 1'b0;
        wait_cycles(4);
        check("R9 mode in reset", mode_data_o, 1'b0);
        check("R9 lock flag in reset", freq_locked_o, 1'b0);
        rst_n = 1'b1;
        wait_cycles(3);
        check("R9 mode after release", mode_data_o, 1'b0);
    endtask

    task automatic t_auto_lock();
        rec_half = 2.5; ppm_sel_i = 3'd0;
        do_reset();
        wait_windows(4.5);
        check("R4/R6 not locked after three counted windows", freq_locked_o, 1'b0);
        wait_windows(1.0);
        check("R3/R6 auto lock after four good windows", freq_locked_o, 1'b1);
        check("R3 mode follows auto lock", mode_data_o, 1'b1);
    endtask

    task automatic t_drop_bad_window();
        rec_half = 2.525;
        wait_windows(2.2);
        check("R7 drop after out-of-range window", mode_data_o, 1'b0);
        rec_half = 2.5;
    endtask

    task automatic t_threshold_narrow();
        rec_half = 2.503; ppm_sel_i = 3'd0;
        do_reset();
        wait_windows(7.0);
        check("R5 62.5 ppm rejects small offset", mode_data_o, 1'b0);
    endtask

    task automatic t_threshold_wide();
        rec_half = 2.503; ppm_sel_i = 3'd7;
        do_reset();
        wait_windows(5.5);
        check("R5 1000 ppm accepts small offset", mode_data_o, 1'b1);
    endtask

    task automatic t_force_data();
        rec_half = 2.525; ppm_sel_i = 3'd0;
        do_reset();
        wait_cycles(20);
        lock_to_data_i = 1'b1;
        wait_cycles(6);
        check("R1 forced data mode", mode_data_o, 1'b1);
        lock_to_ref_i = 1'b1;
        wait_cycles(6);
        check("R1 data override beats ref override", mode_data_o, 1'b1);
        wait_windows(1.0);
        check("R1 held with bad frequency", freq_locked_o, 1'b1);
        lock_to_data_i = 1'b0;
        wait_cycles(6);
        check("R2 forced ref mode", mode_data_o, 1'b0);
        lock_to_ref_i = 1'b0;
        wait_cycles(6);
        check("R10 release enters ref mode", mode_data_o, 1'b0);
        wait_windows(3.0);
        check("R3 auto stays ref with bad frequency", mode_data_o, 1'b0);
    endtask

    task automatic t_force_ref_release();
        rec_half = 2.5; ppm_sel_i = 3'd0;
        do_reset();
        wait_windows(5.5);
        check("R3 locked before ref override", mode_data_o, 1'b1);
        lock_to_ref_i = 1'b1;
        wait_cycles(6);
        check("R2 ref override unlocks", mode_data_o, 1'b0);
        wait_windows(2.0);
        check("R2 ref held with matched clocks", freq_locked_o, 1'b0);
        lock_to_ref_i = 1'b0;
        wait_cycles(6);
        check("R10 release starts from ref mode", mode_data_o, 1'b0);
        wait_windows(3.0);
        check("R10 run restarted after release", mode_data_o, 1'b0);
        wait_windows(2.5);
        check("R6 relock after full run", mode_data_o, 1'b1);
    endtask

    task automatic finish_run();
        check("R8 flag equals mode throughout", r8_mismatch == 0, 1'b1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        t_reset_state();
        t_auto_lock();
        t_drop_bad_window();
        t_threshold_narrow();
        t_threshold_wide();
        t_force_data();
        t_force_ref_release();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge ref_clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule